// File: doc/BRIEF.md
# Dual Prescaled Time Base

This block keeps two free-running time-base counters that a bank of timer channels uses as its reference for match and capture work. Each counter has its own clock source and its own power-of-two prescaler, both set by static configuration inputs. A source can be the system clock or an external clock pin, which passes through a synchronizer with edge detection. The second counter can also advance on an angle tick produced by shaft-tracking logic outside this block. It can also be frozen.

Each channel picks one of the two counters with one select bit. The block presents the chosen count on that channel's slice of a wide output bus. The match and capture comparators that read these counts are outside this block. So is the logic that makes angle ticks.

Top module: `tbase_dual`

## Requirements
- R1: A synchronous active-high reset clears both counters, every channel slice and the prescaler phases. The cycle after reset is asserted shows all zeros.
- R2: With system-clock source (code 0 on either source input) and prescaler field N, a counter advances by one every 2^N clock cycles. With N = 0 it advances on every cycle.
- R3: The external pin passes through two synchronizing flops, then a rising-edge detector. It yields one source event per rising edge, three clock edges after the pin change is sampled. Source code 1 selects it on either counter.
- R4: The prescaler counts source events, not clocks. A counter advances on every 2^N-th event, with N from 0 to 7 (divide by 1 to 128).
- R5: When the second counter's source code is 2 (angle), it advances by exactly one on each cycle that has an angle tick. Its prescaler field has no effect.
- R6: When the second counter's source code is 3, its count holds still whatever the pin and angle inputs do.
- R7: A counter at all ones wraps to zero on its next advance and keeps counting.
- R8: In a cycle where a counter's source code or prescaler field differs from the value registered in the previous cycle, that counter's prescaler phase returns to zero and its count is kept. A source event in that same cycle is discarded.
- R9: Channel slice i (bits i*W up to i*W+W-1) shows the first counter when select bit i is 0 and the second counter when it is 1. The slice is registered one cycle after the counters.
- R10: The two counters are independent. Each follows only its own source code and prescaler field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| angle_tick | input | 1 | One-cycle angle step pulse, synchronous to clk |
| cfg_src_a | input | 1 | First counter source: 0 system, 1 external pin |
| cfg_ps_a | input | PS_W | First counter prescaler exponent N |
| cfg_src_b | input | 2 | Second counter source: 0 system, 1 pin, 2 angle, 3 hold |
| cfg_ps_b | input | PS_W | Second counter prescaler exponent N |
| chan_sel | input | NUM_CH | Per-channel counter select, 1 picks the second counter |
| cnt_a_o | output | CNT_W | First counter value |
| cnt_b_o | output | CNT_W | Second counter value |
| chan_time_o | output | NUM_CH*CNT_W | Per-channel selected count, channel i in slice i |

## Verification
A configuration change and a source event can arrive in the same cycle. This matters most with the system-clock source, where every cycle is an event. The bench provokes this by rewriting the first counter's prescaler field every one to five cycles while it runs on the system clock. It also switches sources while the pin toggles. A cycle-level reference model in the bench expects the coincident event to be discarded and the phase to restart, and every cycle's counters and channel slices are compared against it. The counter wrap is also run while channel selects change at random, so a wrapped value must reach the right slices on the next cycle.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_ANGLE = 2'd2,
    SRC_HOLD  = 2'd3
  } src_e;
endpackage

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R3: an edge pulse never lasts two cycles
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tbase_stage.sv
module tbase_stage
  import tbase_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             ext_evt_i,
  input  logic             ang_evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PHASE_W = (1 << PS_W) - 1;

  src_e               src;
  logic [1:0]         src_q;
  logic [PS_W-1:0]    ps_q;
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] lim;
  logic [CNT_W-1:0]   cnt_q;
  logic               cfg_chg;
  logic               evt;
  logic               tick;

  assign src = src_e'(src_i);

  always_comb begin
    case (src)
      SRC_SYS:   evt = 1'b1;
      SRC_EXT:   evt = ext_evt_i;
      SRC_ANGLE: evt = ang_evt_i;
      default:   evt = 1'b0;
    endcase
  end

  assign cfg_chg = (src_i != src_q) || (ps_i != ps_q);
  assign lim     = ~({PHASE_W{1'b1}} << ps_i);
  assign tick    = !cfg_chg && evt && ((src == SRC_ANGLE) || (phase_q == lim));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= 2'd0;
      ps_q    <= '0;
      phase_q <= '0;
      cnt_q   <= '0;
    end else begin
      src_q <= src_i;
      ps_q  <= ps_i;
      if (cfg_chg || src == SRC_ANGLE)
        phase_q <= '0;
      else if (evt)
        phase_q <= (phase_q == lim) ? '0 : phase_q + 1'b1;
      if (tick)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_chg |-> phase_q <= lim);
  assert_step_or_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  assert_change_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> cnt_q == $past(cnt_q));
  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    src_i == 2'd3 |=> $stable(cnt_q));
  assert_angle_step_R5: assert property (@(posedge clk) disable iff (rst)
    (src_i == 2'd2 && !cfg_chg && ang_evt_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_angle_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (src_i == 2'd2 && !ang_evt_i) |=> $stable(cnt_q));
  assert_sys_div1_R2: assert property (@(posedge clk) disable iff (rst)
    (src_i == 2'd0 && ps_i == '0 && !cfg_chg) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tbase_chan_mux.sv
module tbase_chan_mux #(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       sel_i,
  input  logic [CNT_W-1:0]        cnt_a_i,
  input  logic [CNT_W-1:0]        cnt_b_i,
  output logic [NUM_CH*CNT_W-1:0] time_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        time_o[i*CNT_W +: CNT_W] <= '0;
      else
        time_o[i*CNT_W +: CNT_W] <= sel_i[i] ? cnt_b_i : cnt_a_i;
    end
  end
endmodule

// File: rtl/tbase_dual.sv
module tbase_dual
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int NUM_CH      = 32,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ext_clk_pin,
  input  logic                    angle_tick,
  input  logic                    cfg_src_a,
  input  logic [PS_W-1:0]         cfg_ps_a,
  input  logic [1:0]              cfg_src_b,
  input  logic [PS_W-1:0]         cfg_ps_b,
  input  logic [NUM_CH-1:0]       chan_sel,
  output logic [CNT_W-1:0]        cnt_a_o,
  output logic [CNT_W-1:0]        cnt_b_o,
  output logic [NUM_CH*CNT_W-1:0] chan_time_o
);
  logic pin_rise;

  tbase_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_clk_pin),
    .rise_o (pin_rise)
  );

  tbase_stage #(.CNT_W(CNT_W), .PS_W(PS_W)) u_stage_a (
    .clk       (clk),
    .rst       (rst),
    .src_i     ({1'b0, cfg_src_a}),
    .ps_i      (cfg_ps_a),
    .ext_evt_i (pin_rise),
    .ang_evt_i (1'b0),
    .cnt_o     (cnt_a_o)
  );

  tbase_stage #(.CNT_W(CNT_W), .PS_W(PS_W)) u_stage_b (
    .clk       (clk),
    .rst       (rst),
    .src_i     (cfg_src_b),
    .ps_i      (cfg_ps_b),
    .ext_evt_i (pin_rise),
    .ang_evt_i (angle_tick),
    .cnt_o     (cnt_b_o)
  );

  tbase_chan_mux #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (chan_sel),
    .cnt_a_i (cnt_a_o),
    .cnt_b_i (cnt_b_o),
    .time_o  (chan_time_o)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cnt_a_o == '0 && cnt_b_o == '0 && chan_time_o == '0));
endmodule

// File: tb/sim_tbase_dual.sv
module sim_tbase_dual;
  localparam int CW  = 10;
  localparam int NCH = 32;
  localparam int PSW = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               pin = 1'b0;
  logic               ang = 1'b0;
  logic               src_a = 1'b0;
  logic [PSW-1:0]     ps_a = '0;
  logic [1:0]         src_b = 2'd0;
  logic [PSW-1:0]     ps_b = '0;
  logic [NCH-1:0]     sel = '0;
  logic [CW-1:0]      cnt_a, cnt_b;
  logic [NCH*CW-1:0]  chan;

  always #4 clk = ~clk;

  tbase_dual #(.CNT_W(CW), .NUM_CH(NCH), .PS_W(PSW)) u0 (
    .clk(clk), .rst(rst), .ext_clk_pin(pin), .angle_tick(ang),
    .cfg_src_a(src_a), .cfg_ps_a(ps_a), .cfg_src_b(src_b), .cfg_ps_b(ps_b),
    .chan_sel(sel), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .chan_time_o(chan)
  );

  typedef struct {
    logic [CW-1:0]     a;
    logic [CW-1:0]     b;
    logic [NCH*CW-1:0] ch;
    string             tag;
  } exp_t;

  exp_t  sb_q[$];
  string cur_tag = "R1";
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // reference state, following the requirements
  bit            m_s1, m_s2, m_s3;
  logic [1:0]    m_srcq [2];
  logic [PSW-1:0] m_psq [2];
  int            m_ph [2];
  logic [CW-1:0] m_cnt [2];
  logic [NCH*CW-1:0] m_ch;

  task automatic step_ctr(input int k, input logic [1:0] s, input logic [PSW-1:0] p,
                          input bit ext_e, input bit ang_e);
    bit chg, ev, tk;
    int lim;
    chg = (s != m_srcq[k]) || (p != m_psq[k]);
    case (s)
      2'd0: ev = 1'b1;
      2'd1: ev = ext_e;
      2'd2: ev = ang_e;
      default: ev = 1'b0;
    endcase
    lim = (1 << p) - 1;
    tk = 1'b0;
    if (chg || s == 2'd2) begin
      m_ph[k] = 0;
      tk = !chg && ev;
    end else if (ev) begin
      if (m_ph[k] == lim) begin tk = 1'b1; m_ph[k] = 0; end
      else m_ph[k] = m_ph[k] + 1;
    end
    if (tk) m_cnt[k] = m_cnt[k] + 1'b1;
    m_srcq[k] = s;
    m_psq[k]  = p;
  endtask

  task automatic predict();
    exp_t e;
    bit ext_e;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ch = '0;
      for (int k = 0; k < 2; k++) begin
        m_srcq[k] = 2'd0; m_psq[k] = '0; m_ph[k] = 0; m_cnt[k] = '0;
      end
    end else begin
      ext_e = m_s2 & ~m_s3;
      for (int i = 0; i < NCH; i++)
        m_ch[i*CW +: CW] = sel[i] ? m_cnt[1] : m_cnt[0];
      step_ctr(0, {1'b0, src_a}, ps_a, ext_e, 1'b0);
      step_ctr(1, src_b, ps_b, ext_e, ang);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
    e.a = m_cnt[0]; e.b = m_cnt[1]; e.ch = m_ch; e.tag = cur_tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare what the last edge produced, then predict the next edge
  always @(negedge clk) begin
    if (!done) begin
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (cnt_a !== e.a) begin
          n_bad++;
          $display("FAIL %s counter A: got %0h expected %0h", e.tag, cnt_a, e.a);
        end
        n_vec++;
        if (cnt_b !== e.b) begin
          n_bad++;
          $display("FAIL %s counter B: got %0h expected %0h", e.tag, cnt_b, e.b);
        end
        n_vec++;
        if (chan !== e.ch) begin
          n_bad++;
          for (int i = 0; i < NCH; i++)
            if (chan[i*CW +: CW] !== e.ch[i*CW +: CW]) begin
              $display("FAIL %s (R9 path) channel %0d: got %0h expected %0h",
                       e.tag, i, chan[i*CW +: CW], e.ch[i*CW +: CW]);
              break;
            end
        end
      end
      predict();
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    int c = 0;
    while (!done) begin
      @(posedge clk);
      c++;
      if (c > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin : driver
    cur_tag = "R1";
    cyc(3);
    rst = 1'b0;

    cur_tag = "R2";
    sel = 32'hAAAA_AAAA; ps_b = 3'd2;
    cyc(40);

    cur_tag = "R4";
    ps_a = 3'd3; ps_b = 3'd7;
    cyc(300);

    cur_tag = "R8";
    for (int k = 0; k < 30; k++) begin
      ps_a = 3'(k % 4);
      cyc((k % 5) + 1);
    end

    cur_tag = "R3";
    src_a = 1'b1; ps_a = 3'd0; src_b = 2'd1; ps_b = 3'd1;
    for (int k = 0; k < 50; k++) begin
      pin = ~pin;
      cyc(($urandom % 4) + 1);
    end

    cur_tag = "R5";
    src_b = 2'd2; ps_b = 3'd5;
    for (int k = 0; k < 80; k++) begin
      ang = 1'($urandom % 2);
      if (k == 40) ps_b = 3'd1;
      cyc(1);
    end
    ang = 1'b0;

    cur_tag = "R6";
    src_b = 2'd3;
    for (int k = 0; k < 40; k++) begin
      ang = 1'($urandom % 2);
      pin = ~pin;
      cyc(1);
    end
    ang = 1'b0;

    cur_tag = "R10";
    src_a = 1'b1; ps_a = 3'd1; src_b = 2'd0; ps_b = 3'd0;
    for (int k = 0; k < 40; k++) begin
      pin = ~pin;
      cyc(($urandom % 3) + 1);
    end

    cur_tag = "R9";
    src_a = 1'b0; ps_a = 3'd0; ps_b = 3'd1;
    for (int k = 0; k < 60; k++) begin
      sel = $urandom;
      cyc(1);
    end

    cur_tag = "R7";
    for (int k = 0; k < 1100; k++) begin
      sel = (k % 2 == 0) ? 32'h0F0F_0F0F : $urandom;
      cyc(1);
    end

    cur_tag = "R1";
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule